// File: doc/BRIEF.md
# SPI Slave Peripheral with Flagged Byte Handoff

This block is the receive and transmit end of an SPI link on a chip where the remote device provides the serial clock. Software loads a byte into a transmit register and picks one of the four clock polarity and phase combinations. When the remote master selects the block and clocks it, the byte leaves on MISO, most significant bit first, while a byte arrives on MOSI. Every completed byte is copied into a receive buffer. A done flag and an optional interrupt tell software that the byte is there.

The serial pins are brought into the system clock domain through two-flop synchronizers. All edge detection runs on the synchronized copies, so the system clock must run at least four times faster than SCK.

The bus side guards against two software mistakes. A byte that arrives before software has cleared the previous one is recorded as an overrun. A transmit write made while the block is selected is dropped and recorded as a collision. The done flag clears only through a fixed sequence: a status read, then a receive-buffer read.

Top module: `spiSlave`

## Requirements
- R1: The bus has three addresses: 0 is the transmit register (write; reads return its contents), 1 is the receive buffer (read), and 2 is control/status. In control/status, bit0 is enable, bit1 is masterSel, bit2 is cpol, bit3 is cpha and bit4 is irqEn; all five are read/write. Bits 7, 6 and 5 are read-only and are done, wcol and ovr. Reset clears every register and flag. The block acts as a slave only when enable=1 and masterSel=0. Otherwise misoEn stays 0 and no byte completes.
- R2: A transfer moves 8 bits in each direction at the same time, MSB first. Input bits are captured on the rising SCK edge when cpol equals cpha, and on the falling edge otherwise. MISO changes on the opposite edge.
- R3: With cpha=0, misoOut shows bit 7 of the transmit register once ssN falls, before the first SCK edge. Each ssN low period carries one byte.
- R4: With cpha=1, ssN may stay low across several bytes. Every byte reloads the transmit register at its first SCK edge.
- R5: When the 8th bit is captured and done is clear, the byte goes into the receive buffer and done is set. The irq output equals done AND irqEn.
- R6: done, wcol and ovr clear only when the receive buffer is read after a status read made while any of those flags was set. A receive read without that prior status read changes nothing.
- R7: While done is set and no status read has occurred since the byte completed, writes to the transmit register are ignored and set no flag.
- R8: If a byte completes while done is still set, ovr is set and the receive buffer keeps the earlier byte.
- R9: While the slave is selected (ssN low), a transmit write is discarded and sets wcol.
- R10: While ssN is high, the bit counter is held at zero and misoEn is 0. A partial byte is therefore dropped, and the next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write qualifier |
| busRd | input | 1 | Read qualifier (read side effects) |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| sckIn | input | 1 | Serial clock from master |
| mosiIn | input | 1 | Serial data in |
| ssN | input | 1 | Slave select, active low |
| misoOut | output | 1 | Serial data out |
| misoEn | output | 1 | MISO output enable (0 = high impedance) |
| irq | output | 1 | Byte-complete interrupt request |

## Verification
The assertions assume the following about the inputs:
- The SCK period is at least eight system clocks.
- The mode and enable bits are changed only while ssN is high.
- ssN never moves in the same system clock as an SCK edge.
- SCK sits at its idle level whenever ssN changes.

The bench master model is built to stay inside these limits. It uses a half period of eight system clocks and parks SCK at the cpol level before every selection. It inserts settling gaps around ssN, and it reprograms the mode only between selections. Random bytes and modes vary only the data and the configuration, never this timing.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam logic [1:0] ADDR_TX   = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int CTRL_BITS = 5;

  typedef struct packed {
    logic active;     // selected and enabled as slave
    logic loadTx;     // copy transmit register into shifter
    logic shiftTx;    // advance the outgoing bit
    logic sampleBit;  // capture mosiBit
    logic byteDone;   // last bit of the byte captured
    logic mosiBit;    // synchronized serial input
  } slvStrobe_t;
endpackage

// File: rtl/spiSlaveCtrl.sv
module spiSlaveCtrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       mosiIn,
  input  logic       ssN,
  input  logic       enable,
  input  logic       masterSel,
  input  logic       cpol,
  input  logic       cpha,
  output slvStrobe_t strb
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSync, ssSync, mosiSync;
  logic sckPrev, ssPrev;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      ssSync   <= '1;
      mosiSync <= '0;
      sckPrev  <= 1'b0;
      ssPrev   <= 1'b1;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      ssSync   <= {ssSync[SYNC_STAGES-2:0], ssN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sckPrev  <= sckSync[SYNC_STAGES-1];
      ssPrev   <= ssSync[SYNC_STAGES-1];
    end
  end

  logic sckNow, ssNow, sckRise, sckFall, ssFall, sampleEdge, driveEdge, active;
  always_comb begin
    sckNow     = sckSync[SYNC_STAGES-1];
    ssNow      = ssSync[SYNC_STAGES-1];
    sckRise    = sckNow & ~sckPrev;
    sckFall    = ~sckNow & sckPrev;
    ssFall     = ~ssNow & ssPrev;
    sampleEdge = (cpol ^ cpha) ? sckFall : sckRise;
    driveEdge  = (cpol ^ cpha) ? sckRise : sckFall;
    active     = enable & ~masterSel & ~ssNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitCnt <= '0;
    else if (!active)        bitCnt <= '0;
    else if (sampleEdge)     bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    strb.active    = active;
    strb.loadTx    = active & ((~cpha & ssFall) | (cpha & driveEdge & (bitCnt == '0)));
    strb.shiftTx   = active & driveEdge & ~strb.loadTx;
    strb.sampleBit = active & sampleEdge;
    strb.byteDone  = active & sampleEdge & (bitCnt == LAST_BIT);
    strb.mosiBit   = mosiSync[SYNC_STAGES-1];
  end

  // R10: a deselected slave restarts from bit zero
  p_idle_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> bitCnt == '0);
  // R2: a completed byte always follows a capture on the last bit
  p_done_on_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |-> strb.sampleBit);
endmodule

// File: rtl/spiSlaveDatapath.sv
module spiSlaveDatapath
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  slvStrobe_t        strb,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              enable,
  output logic              masterSel,
  output logic              cpol,
  output logic              cpha,
  output logic              misoOut,
  output logic              misoEn,
  output logic              irq
);
  logic [CTRL_BITS-1:0] ctrlReg;
  logic [DATA_W-1:0] txReg, txShift, rxShift, rxBuf, rxWord;
  logic done, wcol, ovr, armed;
  logic wrTx, wrCtrl, rdRx, rdStat, irqEn;

  always_comb begin
    wrTx   = busSel & busWr & (busAddr == ADDR_TX);
    wrCtrl = busSel & busWr & (busAddr == ADDR_CTRL);
    rdRx   = busSel & busRd & (busAddr == ADDR_RX);
    rdStat = busSel & busRd & (busAddr == ADDR_CTRL);
    {irqEn, cpha, cpol, masterSel, enable} = ctrlReg;
    rxWord = {rxShift[DATA_W-2:0], strb.mosiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= busWdata[CTRL_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '0;
    else if (wrTx && !strb.active && !(done && !armed)) txReg <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.loadTx)       txShift <= txReg;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.sampleBit)    rxShift <= rxWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0; done <= 1'b0; wcol <= 1'b0; ovr <= 1'b0; armed <= 1'b0;
    end else begin
      if (strb.byteDone) begin
        armed <= 1'b0;
        if (done) ovr <= 1'b1;
        else begin
          rxBuf <= rxWord;
          done  <= 1'b1;
        end
      end else if (rdRx && armed) begin
        done <= 1'b0; wcol <= 1'b0; ovr <= 1'b0; armed <= 1'b0;
      end else if (rdStat && (done || wcol || ovr)) begin
        armed <= 1'b1;
      end
      if (wrTx && strb.active) wcol <= 1'b1;
    end
  end

  always_comb begin
    misoEn  = strb.active;
    misoOut = strb.active ? txShift[DATA_W-1] : 1'b0;
    irq     = done & irqEn;
    case (busAddr)
      ADDR_TX:   busRdata = txReg;
      ADDR_RX:   busRdata = rxBuf;
      ADDR_CTRL: busRdata = DATA_W'({done, wcol, ovr, ctrlReg});
      default:   busRdata = '0;
    endcase
  end

  // R5: done only rises on a completed byte
  p_done_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strb.byteDone));
  // R6: done only falls on an armed receive read
  p_clear_seq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(rdRx && armed));
  // R7: un-armed writes while done is set leave the register untouched
  p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && done && !armed) |=> $stable(txReg));
  // R8: overrun only from a byte landing on a pending one
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovr) |-> $past(strb.byteDone && done));
  // R9: selected slave keeps its transmit register frozen
  p_tx_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> $stable(txReg));
  // R9: collision flag only from a write during selection
  p_wcol_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcol) |-> $past(wrTx && strb.active));
endmodule

// File: rtl/spiSlave.sv
module spiSlave
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssN,
  output logic              misoOut,
  output logic              misoEn,
  output logic              irq
);
  slvStrobe_t strb;
  logic enable, masterSel, cpol, cpha;

  spiSlaveCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssN(ssN),
    .enable(enable), .masterSel(masterSel), .cpol(cpol), .cpha(cpha), .strb(strb)
  );

  spiSlaveDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busSel(busSel), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .enable(enable), .masterSel(masterSel), .cpol(cpol), .cpha(cpha),
    .misoOut(misoOut), .misoEn(misoEn), .irq(irq)
  );
endmodule

// File: tb/test_spiSlave.sv
module test_spiSlave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busWr = 0, busRd = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic sckIn = 0, mosiIn = 0, ssN = 1;
  logic misoOut, misoEn, irq;
  int checks = 0, fails = 0;
  logic cpolM = 0, cphaM = 0;

  spiSlave i_spiSlave (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busSel = 1; busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0; busRd = 0;
  endtask

  function automatic logic [7:0] ctrlWord(input logic en, input logic ms, input logic pol,
                                          input logic pha, input logic ie);
    return {3'b000, ie, pha, pol, ms, en};
  endfunction

  task automatic setMode(input logic pol, input logic pha, input logic ie);
    cpolM = pol; cphaM = pha; sckIn = pol;
    busWrite(2'd2, ctrlWord(1'b1, 1'b0, pol, pha, ie));
    waitCyc(4);
  endtask

  task automatic ssLow();  ssN = 0; waitCyc(HALF); endtask
  task automatic ssHigh(); ssN = 1; waitCyc(6);    endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      if (!cphaM) begin
        mosiIn = tx[i]; waitCyc(HALF); sckIn = ~sckIn; rx[i] = misoOut;
        waitCyc(HALF); sckIn = ~sckIn;
      end else begin
        sckIn = ~sckIn; mosiIn = tx[i]; waitCyc(HALF);
        sckIn = ~sckIn; rx[i] = misoOut; waitCyc(HALF);
      end
    end
    waitCyc(6);
  endtask

  // full select / transfer / clear cycle with checks
  task automatic fullXfer(input logic pol, input logic pha, input logic ie,
                          input logic [7:0] tx, input logic [7:0] m);
    logic [7:0] got, st, rd;
    setMode(pol, pha, ie);
    busWrite(2'd0, tx);
    ssLow();
    if (!pha) check("R3 msb before first edge", misoOut, tx[7]);
    spiBits(m, 8, got);
    ssHigh();
    check("R2 slave byte on MISO", got, tx);
    check("R5 irq follows irqEn", irq, ie);
    busRead(2'd2, st);
    check("R5 done set", st[7:5], 3'b100);
    busRead(2'd1, rd);
    check("R5 rx buffer", rd, m);
    busRead(2'd2, st);
    check("R6 flags cleared", st[7:5], 3'b000);
    check("R6 irq cleared", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, st, got, ta, tb;
    void'($urandom(32'h5EED));
    waitCyc(3); rstN = 1; waitCyc(2);

    busRead(2'd2, st);
    check("R1 reset status", st, 8'h00);
    check("R1 reset misoEn", misoEn, 1'b0);
    check("R1 reset irq", irq, 1'b0);

    // R2 R3 R5 R6: all four modes directed
    for (int md = 0; md < 4; md++)
      fullXfer(md[1], md[0], md[0], 8'hA5 ^ 8'(md * 17), 8'h3C + 8'(md));

    // R1: control readback
    busRead(2'd2, st);
    check("R1 control readback", st[4:0], 5'b11101);

    // R6: rx read without status read does nothing
    setMode(0, 0, 1);
    busWrite(2'd0, 8'h11); ssLow(); spiBits(8'h96, 8, got); ssHigh();
    busRead(2'd1, d);
    busRead(2'd1, d);
    check("R6 still done", irq, 1'b1);
    // R7: gated write before the status read
    busWrite(2'd0, 8'h77);
    busRead(2'd0, d);
    check("R7 write ignored", d, 8'h11);
    busRead(2'd2, st);
    check("R7 no wcol from gate", st[7:5], 3'b100);
    busWrite(2'd0, 8'h5A);
    busRead(2'd0, d);
    check("R7 write after status read", d, 8'h5A);
    busRead(2'd1, d);
    check("R6 buffer value", d, 8'h96);
    check("R6 cleared irq", irq, 1'b0);

    // R8: overrun keeps the first byte (cpha=1 lets ssN stay low)
    setMode(1, 1, 0);
    ssLow(); spiBits(8'hC3, 8, got); spiBits(8'h24, 8, got); ssHigh();
    busRead(2'd2, st);
    check("R8 overrun flags", st[7:5], 3'b101);
    busRead(2'd1, d);
    check("R8 first byte kept", d, 8'hC3);
    busRead(2'd2, st);
    check("R8 flags cleared", st[7:5], 3'b000);

    // R4: three bytes in one selection
    setMode(0, 1, 0);
    busWrite(2'd0, 8'hE1);
    ssLow();
    for (int k = 0; k < 3; k++) begin
      ta = 8'($urandom);
      spiBits(ta, 8, got);
      check("R4 repeated tx byte", got, 8'hE1);
      busRead(2'd2, st);
      busRead(2'd1, d);
      check("R4 byte received", d, ta);
    end
    // R9: write during selection
    busWrite(2'd0, 8'h0F);
    busRead(2'd0, d);
    check("R9 tx frozen", d, 8'hE1);
    busRead(2'd2, st);
    check("R9 wcol set", st[7:5], 3'b010);
    spiBits(8'h42, 8, got);
    check("R9 old byte sent", got, 8'hE1);
    ssHigh();
    busRead(2'd2, st);
    busRead(2'd1, d);
    busRead(2'd2, st);
    check("R9 wcol cleared", st[7:5], 3'b000);

    // R10: partial byte dropped
    setMode(0, 0, 0);
    busWrite(2'd0, 8'hB4);
    ssLow(); spiBits(8'hFF, 3, got); ssHigh();
    check("R10 misoEn released", misoEn, 1'b0);
    busRead(2'd2, st);
    check("R10 no done from partial", st[7:5], 3'b000);
    ssLow(); spiBits(8'h69, 8, got); ssHigh();
    check("R10 fresh byte sent", got, 8'hB4);
    busRead(2'd2, st); busRead(2'd1, d);
    check("R10 fresh byte received", d, 8'h69);

    // R1: disabled and master-selected configurations do nothing
    busWrite(2'd2, ctrlWord(0, 0, 0, 0, 1));
    ssLow();
    check("R1 disabled misoEn", misoEn, 1'b0);
    spiBits(8'h81, 8, got); ssHigh();
    busRead(2'd2, st);
    check("R1 disabled no done", st[7:5], 3'b000);
    busWrite(2'd2, ctrlWord(1, 1, 0, 0, 1));
    ssLow();
    check("R1 master misoEn", misoEn, 1'b0);
    spiBits(8'h18, 8, got); ssHigh();
    check("R1 master no irq", irq, 1'b0);

    // random modes and bytes
    for (int it = 0; it < 24; it++) begin
      d = 8'($urandom);
      ta = 8'($urandom); tb = 8'($urandom);
      fullXfer(d[0], d[1], d[2], ta, tb);
    end

    summary();
  end
endmodule